// File: doc/BRIEF.md
# Trigger Marker Positioner

This block keeps the two trigger marker positions used by an oscilloscope-style display: a level marker, held as a screen row, and a time marker, held as a screen column. Four directional push buttons move them. Up and down move the level marker. Left and right move the time marker. Each button press moves its marker by exactly one step, whether the button is held or bounces.

Each button first passes through a two-flop synchroniser. It then goes through a counter debouncer, which accepts a new level only after the input has held that level for `DEB_CYCLES` consecutive clocks. Only a rising edge of the debounced level counts as a press. Both positions are clamped to the plot area and are fed straight to the screen renderer.

Top module: `trig_marker_pos`

## Requirements
- R1: During and after reset, `level_pos` is `LVL_INIT` (default 220) and `time_pos` is `TIM_INIT` (default 320).
- R2: An up press (`btn_up`) lowers `level_pos` by `STEP` (default 10). A down press (`btn_down`) raises it by `STEP`. No single update changes it by more than `STEP`.
- R3: A left press (`btn_left`) lowers `time_pos` by `STEP`. A right press (`btn_right`) raises it by `STEP`.
- R4: A button held high for any length of time gives exactly one move. A marker never changes on two consecutive clocks.
- R5: A pulse shorter than `DEB_CYCLES` clocks gives no move. A press whose edges bounce with pulses shorter than `DEB_CYCLES` gives exactly one move.
- R6: `level_pos` stays within `LVL_MIN`..`LVL_MAX` (default 20..420). A step that would leave that range stops at the limit.
- R7: `time_pos` stays within `TIM_MIN`..`TIM_MAX` (default 20..620). A step that would leave that range stops at the limit.
- R8: If up and down are pressed together, `level_pos` keeps its value. If left and right are pressed together, `time_pos` keeps its value.
- R9: Level buttons never change `time_pos`, and time buttons never change `level_pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_up | input | 1 | Raw button: level marker up (row decreases) |
| btn_down | input | 1 | Raw button: level marker down (row increases) |
| btn_left | input | 1 | Raw button: time marker left (column decreases) |
| btn_right | input | 1 | Raw button: time marker right (column increases) |
| level_pos | output | POS_W | Level marker row |
| time_pos | output | POS_W | Time marker column |

## Verification
Any internal fault shows on the two position outputs within a few clocks after a debounced edge. A debouncer or edge detector that lets a held or bouncing button through gives extra steps, which the bench sees as a position off by a multiple of `STEP` after that press. A bad clamp gives a position outside the plot range, or a position that is not at the limit after the bench drives a marker past its end. A wrong pairing of buttons shows up as movement on the other marker.

// File: rtl/trig_marker_pos.sv
module trig_marker_pos #(
  parameter int POS_W      = 10,
  parameter int DEB_CYCLES = 250000,
  parameter int STEP       = 10,
  parameter int LVL_MIN    = 20,
  parameter int LVL_MAX    = 420,
  parameter int TIM_MIN    = 20,
  parameter int TIM_MAX    = 620,
  parameter int LVL_INIT   = 220,
  parameter int TIM_INIT   = 320
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             btn_up,
  input  logic             btn_down,
  input  logic             btn_left,
  input  logic             btn_right,
  output logic [POS_W-1:0] level_pos,
  output logic [POS_W-1:0] time_pos
);
  localparam int CW = (DEB_CYCLES > 1) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0]    CNT_LAST = CW'(DEB_CYCLES - 1);
  localparam logic [POS_W-1:0] STEP_V   = POS_W'(STEP);
  localparam logic [POS_W-1:0] L_LO     = POS_W'(LVL_MIN);
  localparam logic [POS_W-1:0] L_HI     = POS_W'(LVL_MAX);
  localparam logic [POS_W-1:0] T_LO     = POS_W'(TIM_MIN);
  localparam logic [POS_W-1:0] T_HI     = POS_W'(TIM_MAX);
  localparam logic [POS_W-1:0] L_LO_S   = POS_W'(LVL_MIN + STEP);
  localparam logic [POS_W-1:0] L_HI_S   = POS_W'(LVL_MAX - STEP);
  localparam logic [POS_W-1:0] T_LO_S   = POS_W'(TIM_MIN + STEP);
  localparam logic [POS_W-1:0] T_HI_S   = POS_W'(TIM_MAX - STEP);

  logic [3:0] raw, meta, sync, deb, deb_q, press;
  assign raw = {btn_right, btn_left, btn_down, btn_up};

  for (genvar i = 0; i < 4; i++) begin : g_btn
    logic [CW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i]  <= 1'b0;
        sync[i]  <= 1'b0;
        deb[i]   <= 1'b0;
        deb_q[i] <= 1'b0;
        cnt      <= '0;
      end else begin
        meta[i]  <= raw[i];
        sync[i]  <= meta[i];
        deb_q[i] <= deb[i];
        if (sync[i] == deb[i]) begin
          cnt <= '0;
        end else if (cnt == CNT_LAST) begin
          deb[i] <= sync[i];
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
    assign press[i] = deb[i] & ~deb_q[i];
  end

  wire lvl_dec = press[0] & ~press[1];
  wire lvl_inc = press[1] & ~press[0];
  wire tim_dec = press[2] & ~press[3];
  wire tim_inc = press[3] & ~press[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_pos <= POS_W'(LVL_INIT);
      time_pos  <= POS_W'(TIM_INIT);
    end else begin
      if (lvl_dec)      level_pos <= (level_pos < L_LO_S) ? L_LO : level_pos - STEP_V;
      else if (lvl_inc) level_pos <= (level_pos > L_HI_S) ? L_HI : level_pos + STEP_V;
      if (tim_dec)      time_pos  <= (time_pos < T_LO_S) ? T_LO : time_pos - STEP_V;
      else if (tim_inc) time_pos  <= (time_pos > T_HI_S) ? T_HI : time_pos + STEP_V;
    end
  end
endmodule

// File: rtl/trig_marker_pos_chk.sv
module trig_marker_pos_chk #(
  parameter int POS_W    = 10,
  parameter int STEP     = 10,
  parameter int LVL_MIN  = 20,
  parameter int LVL_MAX  = 420,
  parameter int TIM_MIN  = 20,
  parameter int TIM_MAX  = 620,
  parameter int LVL_INIT = 220,
  parameter int TIM_INIT = 320
) (
  input logic             clk,
  input logic             rst_n,
  input logic [POS_W-1:0] level_pos,
  input logic [POS_W-1:0] time_pos
);
  // R1
  reset_value_chk: assert property (@(posedge clk)
    !rst_n |=> (level_pos == POS_W'(LVL_INIT) && time_pos == POS_W'(TIM_INIT)));

  // R6
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_pos >= POS_W'(LVL_MIN) && level_pos <= POS_W'(LVL_MAX));

  // R7
  time_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    time_pos >= POS_W'(TIM_MIN) && time_pos <= POS_W'(TIM_MAX));

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((level_pos >= $past(level_pos) ? level_pos - $past(level_pos)
                                              : $past(level_pos) - level_pos) <= POS_W'(STEP)));

  // R4
  level_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_pos != $past(level_pos)) |=> $stable(level_pos));

  // R4
  time_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (time_pos != $past(time_pos)) |=> $stable(time_pos));
endmodule

bind trig_marker_pos trig_marker_pos_chk #(
  .POS_W(POS_W), .STEP(STEP), .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX),
  .TIM_MIN(TIM_MIN), .TIM_MAX(TIM_MAX), .LVL_INIT(LVL_INIT), .TIM_INIT(TIM_INIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .level_pos(level_pos), .time_pos(time_pos)
);

// File: tb/trig_marker_pos_bench.sv
module trig_marker_pos_bench;
  localparam int CLK_PERIOD = 40;
  localparam int DEB = 4;
  localparam int STEP = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] btn = 4'b0;
  logic [9:0] level_pos, time_pos;
  int n_chk = 0, n_bad = 0;
  int exp_lvl = 220, exp_tim = 320;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_marker_pos #(.DEB_CYCLES(DEB)) u_trig_marker_pos (
    .clk(clk), .rst_n(rst_n),
    .btn_up(btn[0]), .btn_down(btn[1]), .btn_left(btn[2]), .btn_right(btn[3]),
    .level_pos(level_pos), .time_pos(time_pos));

  function automatic int step_pos(int p, bit dec, bit inc, int lo, int hi);
    if (dec && !inc) return (p - STEP < lo) ? lo : p - STEP;
    if (inc && !dec) return (p + STEP > hi) ? hi : p + STEP;
    return p;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_both(string req);
    check(req, level_pos, exp_lvl);
    check(req, time_pos, exp_tim);
  endtask

  task automatic press(logic [3:0] m, int hold, bit bounce, string req);
    if (bounce) for (int i = 0; i < 3; i++) begin btn = m; cycles(1); btn = 0; cycles(1); end
    btn = m; cycles(hold);
    if (bounce) for (int i = 0; i < 3; i++) begin btn = 0; cycles(1); btn = m; cycles(1); end
    btn = 0; cycles(DEB + 8);
    exp_lvl = step_pos(exp_lvl, m[0], m[1], 20, 420);
    exp_tim = step_pos(exp_tim, m[2], m[3], 20, 620);
    check_both(req);
  endtask

  initial begin
    cycles(3);
    check_both("R1");
    rst_n = 1'b1;
    cycles(5);
    check_both("R1");
    press(4'b0001, DEB + 4, 0, "R2"); // up: 210
    press(4'b0010, DEB + 4, 0, "R2");
    press(4'b0010, DEB + 4, 0, "R2"); // 230
    press(4'b0100, DEB + 4, 0, "R3");
    press(4'b1000, DEB + 4, 0, "R3");
    press(4'b1000, DEB + 4, 0, "R9");
    press(4'b0001, 120, 0, "R4");
    press(4'b0100, DEB + 4, 1, "R5");
    btn = 4'b0001; cycles(DEB - 1); btn = 0; cycles(DEB + 8);
    check_both("R5");
    press(4'b0011, DEB + 4, 0, "R8");
    press(4'b1100, DEB + 4, 0, "R8");
    for (int i = 0; i < 25; i++) press(4'b0001, DEB + 3, 0, "R6");
    check("R6", level_pos, 20);
    for (int i = 0; i < 45; i++) press(4'b0010, DEB + 3, 0, "R6");
    check("R6", level_pos, 420);
    for (int i = 0; i < 35; i++) press(4'b0100, DEB + 3, 0, "R7");
    check("R7", time_pos, 20);
    for (int i = 0; i < 65; i++) press(4'b1000, DEB + 3, 0, "R7");
    check("R7", time_pos, 620);
    void'($urandom(1234));
    for (int i = 0; i < 300; i++) begin
      logic [3:0] m = 4'($urandom_range(1, 15));
      press(m, DEB + 2 + int'($urandom_range(0, 30)), bit'($urandom_range(0, 1)), "R9");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule